// File: doc/BRIEF.md
# Status-Capturing JTAG Test Access Port

This block is an IEEE 1149.1 test access port. It has the 16-state TAP controller, a 4-bit instruction register, a single-bit bypass register and a 32-bit identification register. The controller advances on the rising edge of the test clock. TDO and the instruction shadow register change on the falling edge, so an external tester always sees stable data when it samples on the next rising edge.

The instruction register also carries status. In Capture-IR its two upper cells take the values of two live status inputs. Its two lower cells load the fixed pattern that 1149.1 requires (binary 01 read from the LSB). The status bits then come out first-in-last during Shift-IR, alongside the fixed marker bits. Instruction 0xE selects the identification register, and every other code selects bypass. Test-Logic-Reset selects the identification instruction, so a board-level ID read works right after reset with no IR scan.

The block has plain control pins only and no stream interface. The tester sets the pace through TCK and TMS, so there is no back-pressure to manage.

Top module: `jtag_tap_status`

## Requirements
- R1: While trst_n is low the port is in Test-Logic-Reset, tdo_en is 0 and tdo is 0. After trst_n rises, a DR scan with no IR scan first returns the identification value, because reset selects instruction 0xE.
- R2: Five consecutive TCK rising edges with TMS high reach Test-Logic-Reset from any state, including the middle of a DR shift. The instruction then becomes 0xE again.
- R3: In Capture-IR, IR cell 0 (nearest TDO, shifted out first) loads 1 and cell 1 loads 0. Cell 2 loads status_lo and cell 3 loads status_hi. A 4-bit IR scan therefore returns {status_hi, status_lo, 0, 1}, MSB first.
- R4: Bits shifted into the IR, LSB first, take effect only when the shadow register loads on the falling TCK edge in Update-IR.
- R5: With instruction 0xE, Capture-DR loads the 32-bit ID_VALUE parameter with bit 0 forced to 1. Shift-DR presents it on TDO LSB first while TDI enters at bit 31.
- R6: With instruction 0xF, the bypass register sits between TDI and TDO. It captures 0, and each TDI bit appears on TDO one shift later.
- R7: Every instruction code other than 0xE, such as 0x0 and 0x3, selects bypass.
- R8: tdo_en is 1 only while the controller is in Shift-IR or Shift-DR. tdo and tdo_en change only on the falling edge of TCK.
- R9: The Pause-DR and Pause-IR states, reached through Exit1 and left through Exit2 back to Shift, keep the partly shifted register intact. The scan then resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Serial test data in, sampled on rising TCK |
| status_hi | input | 1 | Status captured into IR cell 3 |
| status_lo | input | 1 | Status captured into IR cell 2 |
| tdo | output | 1 | Serial test data out, updated on falling TCK |
| tdo_en | output | 1 | TDO drive enable, high in the shift states |

## Verification
The hardest situations to reach from the pins are scans that do not run straight through. One is a shift broken by a pause and then resumed. The other is a TMS-driven reset issued in the middle of a data shift. The bench reaches both by walking explicit TMS sequences through Exit1, Pause and Exit2. It then checks that the resumed bits carry on from the pre-pause contents, and that a later plain DR scan shows the identification instruction is back in force. The status capture is driven with all four combinations of the two status inputs before each IR scan.

// File: rtl/jtap_pkg.sv
package jtap_pkg;

  typedef enum logic [3:0] {
    ST_RESET,  ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  function automatic tap_state_e tap_next(input tap_state_e cur, input logic m);
    tap_state_e nx;
    case (cur)
      ST_RESET:  nx = m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nx = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nx = m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nx = m ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: nx = m ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: nx = m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nx = m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nx = m ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: nx = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nx = m ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nx = m ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: nx = m ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: nx = m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nx = m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nx = m ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: nx = m ? ST_SEL_DR : ST_IDLE;
      default:   nx = ST_RESET;
    endcase
    return nx;
  endfunction

endpackage

// File: rtl/jtap_fsm.sv
module jtap_fsm
  import jtap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_RESET;
    else         state <= tap_next(state, tms);
  end

endmodule

// File: rtl/jtap_ir.sv
module jtap_ir
  import jtap_pkg::*;
#(
  parameter int              IR_W   = 4,
  parameter logic [IR_W-1:0] ID_CMD = 'hE
) (
  input  logic            tck,
  input  logic            trst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  input  logic            status_hi,
  input  logic            status_lo,
  output logic [IR_W-1:0] ir_sr,
  output logic [IR_W-1:0] ir_q,
  output logic            sel_id
);

  localparam int TOP = IR_W - 1;

  logic [IR_W-1:0] cap_pat;

  always_comb begin
    cap_pat        = '0;
    cap_pat[0]     = 1'b1;
    cap_pat[TOP]   = status_hi;
    cap_pat[TOP-1] = status_lo;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr <= '0;
    end else if (state == ST_CAP_IR) begin
      ir_sr <= cap_pat;
    end else if (state == ST_SHF_IR) begin
      ir_sr <= {tdi, ir_sr[TOP:1]};
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_q <= ID_CMD;
    end else if (state == ST_RESET) begin
      ir_q <= ID_CMD;
    end else if (state == ST_UPD_IR) begin
      ir_q <= ir_sr;
    end
  end

  assign sel_id = (ir_q == ID_CMD);

endmodule

// File: rtl/jtap_dr.sv
module jtap_dr
  import jtap_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h4C3A_5E27
) (
  input  logic       tck,
  input  logic       trst_n,
  input  tap_state_e state,
  input  logic       tdi,
  input  logic       sel_id,
  output logic       byp_q,
  output logic       dr_so
);

  localparam logic [ID_W-1:0] ID_CAP = {ID_VALUE[ID_W-1:1], 1'b1};

  logic [ID_W-1:0] id_sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      id_sr <= '0;
      byp_q <= 1'b0;
    end else if (state == ST_CAP_DR) begin
      if (sel_id) id_sr <= ID_CAP;
      byp_q <= 1'b0;
    end else if (state == ST_SHF_DR) begin
      if (sel_id) id_sr <= {tdi, id_sr[ID_W-1:1]};
      else        byp_q <= tdi;
    end
  end

  assign dr_so = sel_id ? id_sr[0] : byp_q;

endmodule

// File: rtl/jtag_tap_status.sv
module jtag_tap_status
  import jtap_pkg::*;
#(
  parameter int              IR_W     = 4,
  parameter int              ID_W     = 32,
  parameter logic [IR_W-1:0] ID_CMD   = 'hE,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h4C3A_5E27
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  input  logic status_hi,
  input  logic status_lo,
  output logic tdo,
  output logic tdo_en
);

  tap_state_e      state_q;
  logic [IR_W-1:0] ir_sr;
  logic [IR_W-1:0] ir_q;
  logic            sel_id;
  logic            byp_q;
  logic            dr_so;

  jtap_fsm u_fsm (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .state  (state_q)
  );

  jtap_ir #(.IR_W(IR_W), .ID_CMD(ID_CMD)) u_ir (
    .tck       (tck),
    .trst_n    (trst_n),
    .state     (state_q),
    .tdi       (tdi),
    .status_hi (status_hi),
    .status_lo (status_lo),
    .ir_sr     (ir_sr),
    .ir_q      (ir_q),
    .sel_id    (sel_id)
  );

  jtap_dr #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
    .tck    (tck),
    .trst_n (trst_n),
    .state  (state_q),
    .tdi    (tdi),
    .sel_id (sel_id),
    .byp_q  (byp_q),
    .dr_so  (dr_so)
  );

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= (state_q == ST_SHF_IR) || (state_q == ST_SHF_DR);
      if (state_q == ST_SHF_IR)      tdo <= ir_sr[0];
      else if (state_q == ST_SHF_DR) tdo <= dr_so;
      else                           tdo <= 1'b0;
    end
  end

endmodule

// File: rtl/jtag_tap_status_chk.sv
module jtag_tap_status_chk
  import jtap_pkg::*;
#(
  parameter int              IR_W   = 4,
  parameter logic [IR_W-1:0] ID_CMD = 'hE
) (
  input logic            tck,
  input logic            trst_n,
  input logic            tms,
  input tap_state_e      state_q,
  input logic [IR_W-1:0] ir_q,
  input logic [IR_W-1:0] ir_sr,
  input logic            byp_q,
  input logic            tdo_en
);

  AST_RESET_SELECTS_ID: assert property (@(posedge tck) disable iff (!trst_n)
    (state_q == ST_RESET) |-> (ir_q == ID_CMD)); // R1

  AST_TMS_HOLDS_RESET: assert property (@(posedge tck) disable iff (!trst_n)
    (state_q == ST_RESET && tms) |=> (state_q == ST_RESET)); // R2

  AST_CAPTURE_IR_MARK: assert property (@(posedge tck) disable iff (!trst_n)
    (state_q == ST_CAP_IR) |=> (ir_sr[1:0] == 2'b01)); // R3

  AST_IR_ONLY_ON_UPDATE: assert property (@(negedge tck) disable iff (!trst_n)
    (state_q != ST_UPD_IR && state_q != ST_RESET) |=> (ir_q == $past(ir_q))); // R4

  AST_BYPASS_CAPTURES_ZERO: assert property (@(posedge tck) disable iff (!trst_n)
    (state_q == ST_CAP_DR) |=> (byp_q == 1'b0)); // R6

  AST_TDO_EN_SHIFT_ONLY: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en == (state_q == ST_SHF_IR || state_q == ST_SHF_DR)); // R8

  AST_PAUSE_KEEPS_IR: assert property (@(posedge tck) disable iff (!trst_n)
    (state_q == ST_PAU_IR) |=> $stable(ir_sr)); // R9

endmodule

bind jtag_tap_status jtag_tap_status_chk #(.IR_W(IR_W), .ID_CMD(ID_CMD)) u_chk (
  .tck     (tck),
  .trst_n  (trst_n),
  .tms     (tms),
  .state_q (state_q),
  .ir_q    (ir_q),
  .ir_sr   (ir_sr),
  .byp_q   (byp_q),
  .tdo_en  (tdo_en)
);

// File: tb/jtag_tap_status_test.sv
`timescale 1ns/1ps
module jtag_tap_status_test;

  localparam logic [31:0] EXP_ID = 32'h4C3A_5E27;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic status_hi = 1'b0;
  logic status_lo = 1'b0;
  logic tdo, tdo_en;
  logic last_en;

  int nvec = 0;
  int nbad = 0;

  always #2 tck = ~tck;

  jtag_tap_status uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .status_hi(status_hi), .status_lo(status_lo),
    .tdo(tdo), .tdo_en(tdo_en)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic so);
    @(negedge tck);
    #1;
    so = tdo;
    last_en = tdo_en;
    tms = m;
    tdi = d;
    @(posedge tck);
  endtask

  task automatic to_idle();
    logic b;
    for (int k = 0; k < 5; k++) step(1'b1, 1'b0, b);
    step(1'b0, 1'b0, b);
  endtask

  task automatic scan_ir(input logic [3:0] code, output logic [3:0] cap);
    logic b;
    step(1'b1, 1'b0, b); step(1'b1, 1'b0, b); step(1'b0, 1'b0, b); step(1'b0, 1'b0, b);
    for (int k = 0; k < 4; k++) begin
      step(k == 3, code[k], b);
      cap[k] = b;
    end
    step(1'b1, 1'b0, b); step(1'b0, 1'b0, b);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    logic b;
    dout = '0;
    step(1'b1, 1'b0, b); step(1'b0, 1'b0, b); step(1'b0, 1'b0, b);
    for (int k = 0; k < n; k++) begin
      step(k == n - 1, din[k], b);
      dout[k] = b;
    end
    step(1'b1, 1'b0, b); step(1'b0, 1'b0, b);
  endtask

  task automatic t_reset();
    logic [63:0] o;
    trst_n = 1'b0;
    #7;
    chk("R1 tdo_en in reset", {63'd0, tdo_en}, 64'd0);
    chk("R1 tdo in reset", {63'd0, tdo}, 64'd0);
    @(negedge tck); trst_n = 1'b1;
    to_idle();
    scan_dr(32, 64'h0, o);
    chk("R1/R5 id after reset", o, {32'd0, EXP_ID});
  endtask

  task automatic t_capture_ir();
    logic [3:0] c;
    for (int s = 0; s < 4; s++) begin
      status_hi = s[1];
      status_lo = s[0];
      scan_ir(4'hE, c);
      chk("R3 capture pattern", {60'd0, c}, {60'd0, s[1], s[0], 2'b01});
    end
    status_hi = 1'b0; status_lo = 1'b0;
  endtask

  task automatic t_bypass(input logic [3:0] code, input string req);
    logic [3:0] c;
    logic [63:0] o;
    logic [63:0] pat = 64'h0000_0000_0000_00B5;
    scan_ir(code, c);
    scan_dr(9, pat, o);
    chk(req, o, {55'd0, pat[7:0], 1'b0});
  endtask

  task automatic t_id_after_bypass();
    logic [3:0] c;
    logic [63:0] o;
    scan_ir(4'hE, c);
    scan_dr(32, 64'hFFFF_FFFF, o);
    chk("R5 id scan", o, {32'd0, EXP_ID});
  endtask

  task automatic t_ir_pause();
    logic b;
    logic [3:0] seg;
    logic [3:0] c;
    logic [63:0] o;
    scan_ir(4'hF, c);
    step(1'b1, 1'b0, b); step(1'b1, 1'b0, b); step(1'b0, 1'b0, b); step(1'b0, 1'b0, b);
    for (int k = 0; k < 4; k++) step(k == 3, k < 2, b);
    step(1'b0, 1'b0, b); step(1'b0, 1'b0, b); step(1'b0, 1'b0, b);
    step(1'b1, 1'b0, b); step(1'b0, 1'b0, b);
    for (int k = 0; k < 4; k++) begin
      step(k == 3, k != 0, b);
      seg[k] = b;
    end
    chk("R9 ir resumed after pause", {60'd0, seg}, 64'h3);
    step(1'b1, 1'b0, b); step(1'b0, 1'b0, b);
    scan_dr(32, 64'h0, o);
    chk("R4 updated ir selects id", o, {32'd0, EXP_ID});
  endtask

  task automatic t_dr_pause();
    logic b;
    logic [31:0] got;
    step(1'b1, 1'b0, b); step(1'b0, 1'b0, b); step(1'b0, 1'b0, b);
    for (int k = 0; k < 10; k++) begin
      step(k == 9, 1'b0, b);
      got[k] = b;
    end
    step(1'b0, 1'b0, b); step(1'b0, 1'b0, b); step(1'b1, 1'b0, b); step(1'b0, 1'b0, b);
    for (int k = 10; k < 32; k++) begin
      step(k == 31, 1'b0, b);
      got[k] = b;
    end
    step(1'b1, 1'b0, b); step(1'b0, 1'b0, b);
    chk("R9 dr resumed after pause", {32'd0, got}, {32'd0, EXP_ID});
  endtask

  task automatic t_tms_reset();
    logic b;
    logic [3:0] c;
    logic [63:0] o;
    scan_ir(4'hF, c);
    step(1'b1, 1'b0, b); step(1'b0, 1'b0, b); step(1'b0, 1'b0, b);
    step(1'b0, 1'b1, b); step(1'b0, 1'b1, b);
    for (int k = 0; k < 5; k++) step(1'b1, 1'b0, b);
    step(1'b0, 1'b0, b);
    scan_dr(32, 64'h0, o);
    chk("R2 tms reset mid-scan restores id", o, {32'd0, EXP_ID});
  endtask

  task automatic t_enable_timing();
    logic b;
    logic [3:0] c;
    scan_ir(4'hF, c);
    step(1'b1, 1'b0, b); step(1'b0, 1'b0, b);
    step(1'b0, 1'b1, b);
    chk("R8 en low in capture", {63'd0, last_en}, 64'd0);
    step(1'b0, 1'b1, b);
    chk("R8 en high in shift", {63'd0, last_en}, 64'd1);
    #1;
    chk("R8 tdo holds until falling edge", {63'd0, tdo}, 64'd0);
    step(1'b1, 1'b0, b);
    chk("R8 tdo changed at falling edge", {63'd0, b}, 64'd1);
    step(1'b1, 1'b0, b);
    chk("R8 en low in exit1", {63'd0, last_en}, 64'd0);
    step(1'b0, 1'b0, b);
    chk("R8 en low in update", {63'd0, last_en}, 64'd0);
  endtask

  initial begin : watchdog
    #(4 * 150000);
    nbad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    t_reset();
    t_capture_ir();
    t_bypass(4'hF, "R6 bypass 0xF");
    t_bypass(4'h3, "R7 undefined 0x3 bypass");
    t_bypass(4'h0, "R7 undefined 0x0 bypass");
    t_id_after_bypass();
    t_ir_pause();
    t_dr_pause();
    t_tms_reset();
    t_enable_timing();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule